// File: doc/BRIEF.md
# Rising-Edge Phase-Frequency Comparator with Released State

This block compares a reference input with the feedback from an oscillator. It works only on the rising edges of the two inputs, so their duty cycles do not matter. Both inputs are synchronized into the system clock domain, and each rising edge becomes a single-cycle event. A small state memory then decides the charge-pump command, which is one of three levels: push the loop filter up, pull it down, or release it. The released level stands for a high-impedance output and is given as an enable of zero.

When the reference edge comes first, the block drives up until the next feedback edge. When the feedback edge comes first, it drives down until the next reference edge. The loop therefore settles with the two rising edges aligned, and in lock the output stays released except for short corrections. The block also detects frequency: a feedback that runs slow keeps the output mostly up, and one that runs fast keeps it mostly down. A lock-indicating phase-pulse output is high whenever the command is released.

Top module: `phase_freq_det`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, the outputs are `drive_en`=0, `drive_val`=0 and `lock_pulse`=1 (released state).
- R2: From the released state, a reference rising edge with no feedback rising edge in the same cycle gives `drive_en`=1 and `drive_val`=1 (up). The up command stays until a feedback rising edge is seen, and then the output returns to released.
- R3: From the released state, a feedback rising edge with no reference rising edge in the same cycle gives `drive_en`=1 and `drive_val`=0 (down). The down command stays until a reference rising edge is seen, and then the output returns to released.
- R4: When reference and feedback rising edges are resolved in the same system clock cycle, the next state is released, whatever the current state.
- R5: `lock_pulse` equals the inverse of `drive_en` in every cycle, and `drive_val` is 0 whenever `drive_en` is 0.
- R6: Falling edges and input levels have no effect: an input that falls, or stays high, leaves the command unchanged.
- R7: An input change applied before clock edge m shows up on the outputs after clock edge m+SYNC_STAGES. With the default of 2 stages, that is the third edge.
- R8: With no reference edges, any number of feedback rising edges keeps the command at down.
- R9: Extra reference rising edges while up, including short spurious pulses, keep the command up. Extra feedback rising edges while down keep it down.
- R10: When the feedback period is at least 1.5 times the reference period, the output spends more cycles up than down. When the reference period is at least 1.5 times the feedback period, it spends more cycles down than up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| fb_in | input | 1 | Oscillator feedback signal, asynchronous |
| drive_en | output | 1 | 1 = pump driven, 0 = released (high impedance) |
| drive_val | output | 1 | Pump level when driven: 1 = up, 0 = down |
| lock_pulse | output | 1 | High while the pump is released |

## Verification
Directed sequences apply a lone reference edge, a lone feedback edge, edges that land in the same cycle, falling edges alone, and trains of repeated edges on one input. Each of these separates one branch of the up/down memory, and the cycle of the first output change confirms the pipeline latency. A sweep then runs every pairing of a few reference and feedback periods at several phase offsets, and compares the outputs with an arithmetic model in every cycle. Mismatched periods show the frequency-detecting bias. Equal periods with offsets show the alternation between a short correction and release.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    ST_REL = 2'd0,
    ST_UP  = 2'd1,
    ST_DN  = 2'd2
  } pump_st_e;

  typedef struct packed {
    logic en;
    logic val;
    logic lock;
  } pump_cmd_t;

  function automatic pump_cmd_t decode_cmd(input pump_st_e s);
    pump_cmd_t c;
    c.en   = (s != ST_REL);
    c.val  = (s == ST_UP);
    c.lock = (s == ST_REL);
    return c;
  endfunction

  function automatic pump_st_e next_state(input pump_st_e s, input logic r, input logic f);
    pump_st_e n;
    n = s;
    if (r && f) begin
      n = ST_REL;
    end else begin
      unique case (s)
        ST_REL:  n = r ? ST_UP : (f ? ST_DN : ST_REL);
        ST_UP:   n = f ? ST_REL : ST_UP;
        ST_DN:   n = r ? ST_REL : ST_DN;
        default: n = ST_REL;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;

  // R6
  single_rise_chk: assert property (@(posedge clk) disable iff (rst) rise |=> !rise);
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic drive_en,
  output logic drive_val,
  output logic lock_pulse
);
  pump_st_e  state, state_nx;
  pump_cmd_t cmd_nx;

  always_comb begin
    state_nx = next_state(state, ref_rise, fb_rise);
    cmd_nx   = decode_cmd(state_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_REL;
      drive_en   <= 1'b0;
      drive_val  <= 1'b0;
      lock_pulse <= 1'b1;
    end else begin
      state      <= state_nx;
      drive_en   <= cmd_nx.en;
      drive_val  <= cmd_nx.val;
      lock_pulse <= cmd_nx.lock;
    end
  end

  // R2
  up_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UP && !fb_rise) |=> (drive_en && drive_val));
  // R2
  up_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UP && fb_rise) |=> (!drive_en && lock_pulse));
  // R3
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DN && !ref_rise) |=> (drive_en && !drive_val));
  // R4
  both_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && fb_rise) |=> !drive_en);
endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic drive_en,
  output logic drive_val,
  output logic lock_pulse
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw, lvl, rise;

  assign raw = {fb_in, ref_in};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(raw[c]), .q(lvl[c])
    );
    pfd_edge u_edge (
      .clk(clk), .rst(rst), .lvl(lvl[c]), .rise(rise[c])
    );
  end

  pfd_fsm u_fsm (
    .clk(clk),
    .rst(rst),
    .ref_rise(rise[0]),
    .fb_rise(rise[1]),
    .drive_en(drive_en),
    .drive_val(drive_val),
    .lock_pulse(lock_pulse)
  );

  // R5
  lock_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    lock_pulse != drive_en);
  // R5
  val_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    drive_val |-> drive_en);
endmodule

// File: tb/tb_phase_freq_det.sv
module tb_phase_freq_det;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic drive_en, drive_val, lock_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R5";

  // model state: 0 released, 1 up, 2 down
  int mst = 0;
  logic [3:0] hr = 4'b0, hf = 4'b0;
  int up_cnt = 0, dn_cnt = 0;

  localparam logic [2:0] C_REL = 3'b001;
  localparam logic [2:0] C_UP  = 3'b110;
  localparam logic [2:0] C_DN  = 3'b100;

  always #2.5 clk = ~clk;

  phase_freq_det dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .drive_en(drive_en), .drive_val(drive_val), .lock_pulse(lock_pulse)
  );

  function automatic logic [2:0] enc(input int s);
    return (s == 1) ? C_UP : ((s == 2) ? C_DN : C_REL);
  endfunction

  task automatic chk(input string t, input logic [2:0] exp);
    logic [2:0] act;
    act = {drive_en, drive_val, lock_pulse};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", t, $time, act, exp);
    end
  endtask

  // drive inputs for one cycle, sample at next falling edge, compare with model
  task automatic step(input logic r, input logic f);
    logic er, ef;
    ref_in = r;
    fb_in  = f;
    @(negedge clk);
    hr = {hr[2:0], r};
    hf = {hf[2:0], f};
    er = hr[2] & ~hr[3];
    ef = hf[2] & ~hf[3];
    if (er && ef)        mst = 0;
    else if (mst == 0)   mst = er ? 1 : (ef ? 2 : 0);
    else if (mst == 1)   mst = ef ? 0 : 1;
    else                 mst = er ? 0 : 2;
    chk(tag, enc(mst));
    if (drive_en && drive_val)  up_cnt++;
    if (drive_en && !drive_val) dn_cnt++;
  endtask

  task automatic do_reset();
    rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", C_REL);
    rst = 1'b0;
    mst = 0; hr = 4'b0; hf = 4'b0;
    @(negedge clk);
    chk("R1", C_REL);
  endtask

  task automatic pad(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    do_reset();

    // R7 latency, R2 entry to up
    tag = "R7";
    step(1, 0); step(1, 0);
    chk("R7", C_REL);
    step(1, 0);
    chk("R7", C_UP);
    chk("R2", C_UP);

    // R6 falling ref and held level have no effect
    tag = "R6";
    pad(5);
    chk("R6", C_UP);

    // R9 repeated/spurious ref pulses keep up
    tag = "R9";
    step(1, 0); step(0, 0); step(1, 0); step(0, 0); step(1, 0);
    pad(4);
    chk("R9", C_UP);

    // R2 feedback edge releases
    tag = "R2";
    step(0, 1); step(0, 1); step(0, 1);
    chk("R2", C_REL);
    step(0, 0); pad(3);
    chk("R5", C_REL);

    // R3 feedback first -> down
    tag = "R3";
    step(0, 1); step(0, 1); step(0, 1);
    chk("R3", C_DN);
    tag = "R6";
    pad(4);
    chk("R6", C_DN);

    // R8 / R9 feedback edges only keep down
    tag = "R8";
    for (int k = 0; k < 5; k++) begin
      step(0, 1); step(0, 1); step(0, 0); step(0, 0);
    end
    pad(3);
    chk("R8", C_DN);
    chk("R9", C_DN);

    // R3 reference edge releases down
    tag = "R3";
    step(1, 0); step(1, 0); step(1, 0);
    chk("R3", C_REL);
    pad(4);

    // R4 simultaneous edges from released
    tag = "R4";
    step(1, 1); step(1, 1); step(1, 1);
    chk("R4", C_REL);
    pad(4);
    chk("R4", C_REL);
    // enter up, then simultaneous edges
    step(1, 0); step(1, 0); step(1, 0);
    chk("R2", C_UP);
    pad(4);
    step(1, 1); step(1, 1); step(1, 1);
    chk("R4", C_REL);
    pad(4);

    // sweep of periods and phases, R10 bias
    foreach (pr_list[i]) foreach (pf_list[j]) for (int ph = 0; ph < 4; ph++) begin
      int pr, pf;
      pr = pr_list[i];
      pf = pf_list[j];
      do_reset();
      tag = "R10";
      for (int cyc = 0; cyc < 120; cyc++) begin
        if (cyc == 16) begin up_cnt = 0; dn_cnt = 0; end
        step(((cyc + ph) % pr) < (pr / 2), (cyc % pf) < (pf / 2));
      end
      if (pf * 2 >= pr * 3) begin
        checks++;
        if (!(up_cnt > dn_cnt)) begin
          fails++;
          $display("FAIL R10 pr=%0d pf=%0d actual up=%0d dn=%0d expected up>dn", pr, pf, up_cnt, dn_cnt);
        end
      end else if (pr * 2 >= pf * 3) begin
        checks++;
        if (!(dn_cnt > up_cnt)) begin
          fails++;
          $display("FAIL R10 pr=%0d pf=%0d actual up=%0d dn=%0d expected dn>up", pr, pf, up_cnt, dn_cnt);
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int pr_list [3] = '{4, 6, 8};
  int pf_list [4] = '{4, 5, 8, 12};

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule